// File: doc/BRIEF.md
# Iterative Integer Multiply Unit with Flag Generation

This block multiplies two 32-bit integers in one of four forms: unsigned widening, signed widening, signed two-operand truncating, and signed multiply by an immediate, which also truncates. A single shift-add datapath serves all four forms. Signed operands are first reduced to their magnitudes. The product sign is applied after the last step. The unit returns a high and low result word together with a carry/overflow pair, which reports whether the result fit its destination, and sign, zero, parity and auxiliary flags, which follow logical-operation rules on the low word.

The operands arrive already read from registers. The first operand is the accumulator, or the register being multiplied. The second operand is the source register or the immediate. A one-cycle start pulse launches the operation. That pulse is taken only while the unit is idle. A one-cycle done pulse marks the cycle in which the results become valid. The results then hold until the next completion.

Top module: `mul_unit`

## Requirements
- R1: While reset is asserted, and after reset until the first completion, every result word and flag output is 0 and the done output is low.
- R2: With opcode 2'b00 (unsigned widening), both operands are zero-extended. The high output carries bits 63:32 of the 64-bit product and the low output carries bits 31:0.
- R3: With opcode 2'b00, carry and overflow are both 1 exactly when the high 32 bits of the product are nonzero. Otherwise both are 0.
- R4: With opcode 2'b01 (signed widening), both operands are sign-extended. The high and low outputs carry the 64-bit product. Carry and overflow are both 1 exactly when the product differs from the sign extension of its low 32 bits.
- R5: With opcode 2'b10 (two-operand signed) or 2'b11 (signed by immediate), the low output carries bits 31:0 of the signed product and the high output is 0. Carry and overflow are both 1 exactly when the full signed product lies outside the signed 32-bit range.
- R6: The sign flag equals bit 31 of the low output. The zero flag is 1 when the low output is 0. The parity flag is 1 when bits 7:0 of the low output hold an even number of ones. The auxiliary flag is 0.
- R7: A start pulse sampled high on a clock edge while the unit is idle launches an operation. The done output is high for exactly one cycle, in the cycle after the 33rd following edge. From that cycle on, the new results are visible.
- R8: A start pulse that arrives while an operation is in progress is ignored. It does not change the pending result, the done timing or the outputs.
- R9: Between completions, all result and flag outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch pulse, taken only when idle |
| op_i | input | 2 | Form select: 00 unsigned wide, 01 signed wide, 10 signed two-operand, 11 signed immediate |
| src_a_i | input | 32 | Accumulator or destination-register operand |
| src_b_i | input | 32 | Source-register or immediate operand |
| res_hi_o | output | 32 | High product word (0 for truncating forms) |
| res_lo_o | output | 32 | Low product word |
| cf_o | output | 1 | Carry: result did not fit |
| of_o | output | 1 | Overflow: equal to carry |
| sf_o | output | 1 | Sign of low word |
| zf_o | output | 1 | Low word is zero |
| pf_o | output | 1 | Even parity of low byte |
| af_o | output | 1 | Auxiliary carry, always 0 |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
Two events can coincide. The first is an operation completing. The second is a fresh start pulse arriving while the unit is still busy, including in the last busy cycle, just before done rises. The bench provokes this by issuing a second start with different operands and a different form, part-way through an operation and also on its final step edge. A behavioural model accepts starts only when its own countdown is idle. The bench compares every output against that model on every clock. Any absorbed start therefore shows up as a wrong result, a shifted done pulse or a changed held value. The signed boundary cases at the edges of the signed 32-bit range, together with 0x80000000 times 0xFFFFFFFF, judge the fit test in each form.

// File: rtl/mul_unit_pkg.sv
// Package: shared opcode encoding, flag bundle and control states for the
// multiply unit. Assumes a 2-bit form select as listed in the brief.
package mul_unit_pkg;

    typedef enum logic [1:0] {
        MOP_UWIDE = 2'b00,   // unsigned, 64-bit result
        MOP_SWIDE = 2'b01,   // signed, 64-bit result
        MOP_STWO  = 2'b10,   // signed, truncated to low word
        MOP_SIMM  = 2'b11    // signed by immediate, truncated
    } mul_op_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic sf;
        logic zf;
        logic pf;
        logic af;
    } mul_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_FIN  = 2'b10
    } mul_state_e;

    // True when the form treats operands as two's complement.
    function automatic logic op_is_signed(input mul_op_e op);
        return op != MOP_UWIDE;
    endfunction

    // True when the form writes only the low word.
    function automatic logic op_is_trunc(input mul_op_e op);
        return (op == MOP_STWO) || (op == MOP_SIMM);
    endfunction

endpackage

// File: rtl/mul_operand_prep.sv
// Operand preparation: turns both operands into unsigned magnitudes and
// reports whether the final product must be negated. For the unsigned form
// the operands pass through unchanged. The most negative value maps to
// itself, which is its correct unsigned magnitude.
module mul_operand_prep
    import mul_unit_pkg::*;
#(
    parameter int W = 32
) (
    input  mul_op_e        op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   mag_a_o,
    output logic [W-1:0]   mag_b_o,
    output logic           neg_o
);

    logic sgn_mode;
    logic a_neg;
    logic b_neg;

    // Decide which operands are negative under the selected form.
    always_comb begin
        sgn_mode = op_is_signed(op_i);
        a_neg    = sgn_mode & a_i[W-1];
        b_neg    = sgn_mode & b_i[W-1];
    end

    // Produce magnitudes and the product sign.
    always_comb begin
        mag_a_o = a_neg ? (~a_i + {{(W-1){1'b0}}, 1'b1}) : a_i;
        mag_b_o = b_neg ? (~b_i + {{(W-1){1'b0}}, 1'b1}) : b_i;
        neg_o   = a_neg ^ b_neg;
    end

endmodule

// File: rtl/mul_shift_add_core.sv
// Radix-2 shift-add engine. A load captures the multiplicand and multiplier.
// Each step then adds the multiplicand to the upper accumulator when the
// current multiplier bit is set, and shifts the accumulator pair right.
// After W steps the pair holds the unsigned 2W-bit product.
// Assumes load and step are never asserted together.
module mul_shift_add_core #(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic            step_i,
    input  logic [W-1:0]    mcand_i,
    input  logic [W-1:0]    mplier_i,
    output logic [2*W-1:0]  product_o
);

    logic [W-1:0] mcand_q;
    logic [W-1:0] acc_hi_q;
    logic [W-1:0] acc_lo_q;
    logic [W:0]   partial;

    // Conditional add of the multiplicand into the upper half.
    always_comb begin
        partial = {1'b0, acc_hi_q} + (acc_lo_q[0] ? {1'b0, mcand_q} : {(W+1){1'b0}});
    end

    // Accumulator registers: clear, load or one shift-add step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            acc_hi_q <= '0;
            acc_lo_q <= '0;
        end else if (load_i) begin
            mcand_q  <= mcand_i;
            acc_hi_q <= '0;
            acc_lo_q <= mplier_i;
        end else if (step_i) begin
            acc_hi_q <= partial[W:1];
            acc_lo_q <= {partial[0], acc_lo_q[W-1:1]};
        end
    end

    assign product_o = {acc_hi_q, acc_lo_q};

    // R7: the controller must never load and step in the same cycle.
    p_load_step_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && step_i));

    // R8: the multiplicand stays fixed while steps run.
    p_mcand_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> $stable(mcand_q));

endmodule

// File: rtl/mul_result_form.sv
// Result formation: applies the product sign, then places the result for the
// selected form. It also computes the fit test that drives carry and
// overflow, and the logic-style flags taken from the low word.
// Purely combinational.
module mul_result_form
    import mul_unit_pkg::*;
#(
    parameter int W = 32
) (
    input  mul_op_e         op_i,
    input  logic            neg_i,
    input  logic [2*W-1:0]  raw_i,
    output logic [W-1:0]    hi_o,
    output logic [W-1:0]    lo_o,
    output mul_flags_t      flags_o
);

    logic [2*W-1:0] full;
    logic [W:0]     top_bits;
    logic           no_fit;

    // Apply the sign correction to the unsigned magnitude product.
    always_comb begin
        full = neg_i ? (~raw_i + {{(2*W-1){1'b0}}, 1'b1}) : raw_i;
    end

    // Fit test: unsigned needs an empty high word; signed needs bits 2W-1..W-1 equal.
    always_comb begin
        top_bits = full[2*W-1:W-1];
        if (op_is_signed(op_i)) begin
            no_fit = !((top_bits == '0) || (top_bits == '1));
        end else begin
            no_fit = (full[2*W-1:W] != '0);
        end
    end

    // Result placement: truncating forms drive a zero high word.
    always_comb begin
        lo_o = full[W-1:0];
        hi_o = op_is_trunc(op_i) ? '0 : full[2*W-1:W];
    end

    // Flags: carry/overflow from the fit test, the rest from the low word.
    always_comb begin
        flags_o.cf = no_fit;
        flags_o.of = no_fit;
        flags_o.sf = full[W-1];
        flags_o.zf = (full[W-1:0] == '0);
        flags_o.pf = ~^full[7:0];
        flags_o.af = 1'b0;
    end

endmodule

// File: rtl/mul_unit.sv
// Top of the multiply unit. It sequences a W-step shift-add multiply:
// an idle start loads the core, W step cycles follow, and one finish cycle
// registers the formed result and flags while pulsing done. Starts that
// arrive while busy are dropped. Outputs hold between completions.
module mul_unit
    import mul_unit_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [1:0]    op_i,
    input  logic [W-1:0]  src_a_i,
    input  logic [W-1:0]  src_b_i,
    output logic [W-1:0]  res_hi_o,
    output logic [W-1:0]  res_lo_o,
    output logic          cf_o,
    output logic          of_o,
    output logic          sf_o,
    output logic          zf_o,
    output logic          pf_o,
    output logic          af_o,
    output logic          done_o
);

    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    mul_state_e       state_q;
    logic [CW-1:0]    step_cnt_q;
    mul_op_e          op_q;
    logic             neg_q;
    logic             accept;
    logic             step_en;

    mul_op_e          op_in;
    logic [W-1:0]     mag_a;
    logic [W-1:0]     mag_b;
    logic             neg_in;
    logic [2*W-1:0]   raw_prod;
    logic [W-1:0]     form_hi;
    logic [W-1:0]     form_lo;
    mul_flags_t       form_flags;

    assign op_in   = mul_op_e'(op_i);
    assign accept  = (state_q == ST_IDLE) && start_i;
    assign step_en = (state_q == ST_RUN);

    mul_operand_prep #(.W(W)) u_prep (
        .op_i    (op_in),
        .a_i     (src_a_i),
        .b_i     (src_b_i),
        .mag_a_o (mag_a),
        .mag_b_o (mag_b),
        .neg_o   (neg_in)
    );

    mul_shift_add_core #(.W(W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (accept),
        .step_i    (step_en),
        .mcand_i   (mag_a),
        .mplier_i  (mag_b),
        .product_o (raw_prod)
    );

    mul_result_form #(.W(W)) u_form (
        .op_i    (op_q),
        .neg_i   (neg_q),
        .raw_i   (raw_prod),
        .hi_o    (form_hi),
        .lo_o    (form_lo),
        .flags_o (form_flags)
    );

    // Control sequence: idle -> W steps -> finish -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            step_cnt_q <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q    <= ST_RUN;
                        step_cnt_q <= '0;
                    end
                end
                ST_RUN: begin
                    step_cnt_q <= step_cnt_q + 1'b1;
                    if (step_cnt_q == LAST_STEP) begin
                        state_q <= ST_FIN;
                    end
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Capture the form and product sign of an accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= MOP_UWIDE;
            neg_q <= 1'b0;
        end else if (accept) begin
            op_q  <= op_in;
            neg_q <= neg_in;
        end
    end

    // Result registers: updated only in the finish cycle, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi_o <= '0;
            res_lo_o <= '0;
            cf_o     <= 1'b0;
            of_o     <= 1'b0;
            sf_o     <= 1'b0;
            zf_o     <= 1'b0;
            pf_o     <= 1'b0;
            af_o     <= 1'b0;
        end else if (state_q == ST_FIN) begin
            res_hi_o <= form_hi;
            res_lo_o <= form_lo;
            cf_o     <= form_flags.cf;
            of_o     <= form_flags.of;
            sf_o     <= form_flags.sf;
            zf_o     <= form_flags.zf;
            pf_o     <= form_flags.pf;
            af_o     <= form_flags.af;
        end
    end

    // Done pulse: raised for the cycle after the finish edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_FIN);
        end
    end

    // R7: done lasts exactly one cycle.
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: a start seen while busy leaves the captured form unchanged.
    p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start_i) |=> $stable(op_q) && $stable(neg_q));

    // R9: outputs move only after a finish cycle.
    p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_FIN) |=> $stable(res_lo_o) && $stable(res_hi_o) && $stable(cf_o));

    // R3: carry and overflow always agree.
    p_cf_of_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cf_o == of_o);

    // R5: truncating forms never report a high word.
    p_trunc_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && op_is_trunc(op_q)) |-> (res_hi_o == '0));

    // R6: the sign flag follows the top bit of the low word.
    p_sign_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sf_o == res_lo_o[W-1]));

endmodule

// File: tb/mul_unit_bench.sv
module mul_unit_bench;

    localparam int LAT = 33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] src_a_i = '0;
    logic [31:0] src_b_i = '0;
    logic [31:0] res_hi_o, res_lo_o;
    logic        cf_o, of_o, sf_o, zf_o, pf_o, af_o, done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit model_live = 1'b0;

    always #2.5 clk = ~clk;

    mul_unit u_mul_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o),
        .cf_o(cf_o), .of_o(of_o), .sf_o(sf_o), .zf_o(zf_o),
        .pf_o(pf_o), .af_o(af_o), .done_o(done_o)
    );

    // Behavioural reference model state.
    int          cnt = 0;
    logic [1:0]  pend_op;
    logic [31:0] pend_hi, pend_lo;
    logic        pend_cf;
    logic [1:0]  last_op = 2'b00;
    logic        exp_done = 1'b0;
    logic [31:0] exp_hi = '0, exp_lo = '0;
    logic        exp_cf = 1'b0, exp_sf = 1'b0, exp_zf = 1'b0, exp_pf = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference: full 64-bit product from extended operands, then placement and fit.
    always @(posedge clk) begin
        logic [63:0] p;
        logic [63:0] ea, eb;
        model_live <= 1'b1;
        if (!rst_n) begin
            cnt <= 0; exp_done <= 1'b0;
            exp_hi <= '0; exp_lo <= '0; exp_cf <= 1'b0;
            exp_sf <= 1'b0; exp_zf <= 1'b0; exp_pf <= 1'b0;
        end else begin
            exp_done <= 1'b0;
            if (cnt == 0) begin
                if (start_i) begin
                    ea = (op_i == 2'b00) ? {32'h0, src_a_i} : {{32{src_a_i[31]}}, src_a_i};
                    eb = (op_i == 2'b00) ? {32'h0, src_b_i} : {{32{src_b_i[31]}}, src_b_i};
                    p = ea * eb;
                    pend_op <= op_i;
                    pend_lo <= p[31:0];
                    pend_hi <= op_i[1] ? 32'h0 : p[63:32];
                    pend_cf <= (op_i == 2'b00) ? (p[63:32] != 0)
                                               : (p != {{32{p[31]}}, p[31:0]});
                    cnt <= LAT;
                end
            end else begin
                cnt <= cnt - 1;
                if (cnt == 1) begin
                    exp_done <= 1'b1;
                    last_op  <= pend_op;
                    exp_hi   <= pend_hi;
                    exp_lo   <= pend_lo;
                    exp_cf   <= pend_cf;
                    exp_sf   <= pend_lo[31];
                    exp_zf   <= (pend_lo == 0);
                    exp_pf   <= ~^pend_lo[7:0];
                end
            end
        end
    end

    // Compare every output against the model, away from the active edge.
    always @(negedge clk) begin
        string rv, rf;
        if (model_live && !finished) begin
            if (!rst_n) begin
                chk({res_hi_o, res_lo_o, cf_o, of_o, sf_o, zf_o, pf_o, af_o, done_o} == '0,
                    "R1 reset", {res_hi_o, res_lo_o}, 64'h0);
            end else begin
                chk(done_o == exp_done, "R7 done timing", 64'(done_o), 64'(exp_done));
                if (exp_done) begin
                    rv = (last_op == 2'b00) ? "R2 value" : (last_op == 2'b01) ? "R4 value" : "R5 value";
                    rf = (last_op == 2'b00) ? "R3 fit"   : (last_op == 2'b01) ? "R4 fit"   : "R5 fit";
                end else begin
                    rv = "R9 hold value";
                    rf = "R9 hold fit";
                end
                chk({res_hi_o, res_lo_o} == {exp_hi, exp_lo}, rv, {res_hi_o, res_lo_o}, {exp_hi, exp_lo});
                chk(cf_o == exp_cf && of_o == exp_cf, rf, {62'h0, cf_o, of_o}, {62'h0, exp_cf, exp_cf});
                chk({sf_o, zf_o, pf_o, af_o} == {exp_sf, exp_zf, exp_pf, 1'b0},
                    exp_done ? "R6 flags" : "R9 hold flags",
                    64'({sf_o, zf_o, pf_o, af_o}), 64'({exp_sf, exp_zf, exp_pf, 1'b0}));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        issue(op, a, b);
        repeat (LAT + 1) @(negedge clk);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R2/R3 unsigned forms and fit boundary
        run(2'b00, 32'd7, 32'd9);
        run(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run(2'b00, 32'h0000_FFFF, 32'h0001_0001);   // exactly fits: 0xFFFFFFFF
        run(2'b00, 32'h0001_0000, 32'h0001_0000);   // just over: 2^32
        run(2'b00, 32'h8000_0000, 32'hFFFF_FFFF);
        // R4 signed widening
        run(2'b01, 32'h8000_0000, 32'hFFFF_FFFF);   // +2^31 does not fit
        run(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run(2'b01, 32'h4000_0000, 32'hFFFF_FFFE);   // -2^31 fits
        run(2'b01, 32'h8000_0000, 32'h8000_0000);
        // R5 truncating forms at the signed range edges
        run(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
        run(2'b10, 32'h4000_0000, 32'd2);           // +2^31 overflows
        run(2'b10, 32'h7FFF_FFFF, 32'd1);
        run(2'b11, 32'h4000_0000, 32'hFFFF_FFFE);
        run(2'b11, 32'hC000_0000, 32'hFFFF_FFFE);   // +2^31 overflows
        run(2'b11, 32'd12345, 32'd0);               // R6 zero flag
        run(2'b10, 32'h0000_0003, 32'h0000_0001);   // R6 parity even
        run(2'b10, 32'h0000_0007, 32'h0000_0001);   // R6 parity odd
        // R8 start while busy, mid-run and on the final step edge
        issue(2'b00, 32'd100, 32'd200);
        repeat (5) @(negedge clk);
        issue(2'b01, 32'hFFFF_0000, 32'h1234_5678);
        repeat (LAT + 4) @(negedge clk);
        issue(2'b10, 32'd3, 32'd5);
        repeat (LAT - 2) @(negedge clk);
        issue(2'b11, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        repeat (LAT + 4) @(negedge clk);
        // Pseudo-random mix of all forms
        for (int i = 0; i < 40; i++) begin
            run(2'(i % 4), $urandom, $urandom);
        end
        repeat (5) @(negedge clk);
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

endmodule